// File: doc/BRIEF.md
# Rotating-Seed Scrambled Jitter Test Pattern Generator

This block makes a continuous stream of 66-bit data blocks for stressing a serial link during jitter testing. Every block pairs a fixed, unscrambled 2-bit header with a 64-bit word. That word is one programmable payload passed through a self-synchronizing scrambler with polynomial 1 + x^39 + x^58. The scrambler state is forced to a fresh starting value once every seed period, which is a programmable number of blocks. A checker at the far end therefore sees a known start point at regular intervals.

The start values rotate through four phases, held in a phase state machine. The states are SEED_A (code 0), SEED_A_INV (code 1), SEED_B (code 2) and SEED_B_INV (code 3). At every period wrap the machine takes one of two kinds of transition. ADVANCE steps 0→1→2→3→0. HOLD_RETURN goes to SEED_A regardless of the current state, and it is taken whenever the hold-primary input is high at the wrap. In the two inverted states the loaded seed and the payload are both bit-complemented for the whole period. Holding the primary seed gives an endlessly repeated, non-inverted pattern for amplitude measurement. Blocks are produced one per clock while enable is high, and the outputs are registered.

Top module: `jtp_gen`

## Requirements
- R1: After reset, valid_o is 0, hdr_o is 2'b00 and phase_o is 0 (SEED_A). The first enabled block after reset starts the scrambler from seed_a.
- R2: Every block with valid_o high has hdr_o = 2'b01, and hdr_o is 2'b00 whenever valid_o is low.
- R3: blk_o bit i (i = 0 first, up to 63) equals d[i] ^ s[38] ^ s[57]. Here d is the effective payload and s is the 58-bit scrambler state. After each bit, s shifts up by one and the new output bit enters at s[0]. The state carries over from block to block.
- R4: Each cycle with enable high yields one block, with valid_o high on the next cycle. A cycle with enable low yields valid_o = 0, and the scrambler state, block count and phase all stay unchanged.
- R5: The scrambler state is loaded with the phase's seed on the first block of each seed period. The period counts enabled blocks, and a period value of 0 acts as 1, so every block reloads.
- R6: At each period wrap without hold, the phase advances 0→1→2→3→0. Phase 0 uses seed_a, phase 1 uses ~seed_a, phase 2 uses seed_b and phase 3 uses ~seed_b.
- R7: In phases 1 and 3 the payload is complemented before scrambling. With seed and payload both all-zero, a phase-0 block is all zeros and the following phase-1 block is all ones.
- R8: If hold_primary is high at a period wrap, the next period is phase 0 with seed_a. While hold stays high, phase 0 repeats without end. After hold is released, the loop resumes with phase 1 at the next wrap.
- R9: phase_o gives the phase code of the block currently presented on blk_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Produce one block this cycle |
| seed_a | input | 58 | Primary seed |
| seed_b | input | 58 | Secondary seed |
| payload | input | 64 | Data word before inversion and scrambling |
| period | input | 16 | Seed period in blocks (0 acts as 1) |
| hold_primary | input | 1 | Return to and stay on non-inverted seed A |
| hdr_o | output | 2 | Block header |
| blk_o | output | 64 | Scrambled block payload |
| valid_o | output | 1 | Block on blk_o is valid |
| phase_o | output | 2 | Phase code of the presented block |

## Verification
A wrong scrambler state shows up in blk_o on the very next enabled block. It keeps corrupting every block until the next reload, because the error feeds back through the taps. A wrong phase or block count shows up at the following period wrap, both as a wrong phase_o code and as a payload that is or is not complemented. The bench compares every valid block against an independent bit-level model. That model is built as a time-ordered history of output bits, so a discrepancy is caught within one block of where it appears.

// File: rtl/jtp_pkg.sv
package jtp_pkg;

    typedef enum logic [1:0] {
        SEED_A     = 2'd0,
        SEED_A_INV = 2'd1,
        SEED_B     = 2'd2,
        SEED_B_INV = 2'd3
    } jtp_phase_e;

    // Successor in the four-step loop.
    function automatic jtp_phase_e phase_succ(input jtp_phase_e p);
        jtp_phase_e n;
        unique case (p)
            SEED_A:     n = SEED_A_INV;
            SEED_A_INV: n = SEED_B;
            SEED_B:     n = SEED_B_INV;
            SEED_B_INV: n = SEED_A;
            default:    n = SEED_A;
        endcase
        return n;
    endfunction

    function automatic logic phase_is_inverted(input jtp_phase_e p);
        return (p == SEED_A_INV) || (p == SEED_B_INV);
    endfunction

    function automatic logic phase_uses_b(input jtp_phase_e p);
        return (p == SEED_B) || (p == SEED_B_INV);
    endfunction

endpackage

// File: rtl/jtp_phase_fsm.sv
module jtp_phase_fsm
    import jtp_pkg::*;
#(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    input  logic                hold_primary,
    output jtp_phase_e          phase,
    output logic                load_seed,
    output logic                invert
);

    localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

    jtp_phase_e          phase_q, phase_d;
    logic [PERIOD_W-1:0] cnt_q, cnt_d;
    logic [PERIOD_W-1:0] eff_period;
    logic                wrap;

    assign eff_period = (period == '0) ? ONE : period;
    assign wrap       = enable && (cnt_q >= eff_period - ONE);

    // Next-state logic: ADVANCE or HOLD_RETURN on wrap.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (enable) begin
            if (wrap) begin
                cnt_d = '0;
                unique case (hold_primary)
                    1'b1: phase_d = SEED_A;
                    1'b0: phase_d = phase_succ(phase_q);
                    default: phase_d = SEED_A;
                endcase
            end else begin
                cnt_d = cnt_q + ONE;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= SEED_A;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        phase     = phase_q;
        load_seed = (cnt_q == '0);
        invert    = phase_is_inverted(phase_q);
    end

    // R6: a phase change without hold steps by one in the loop.
    a_r6_loop_order: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wrap && !hold_primary) |=> (phase_q == phase_succ($past(phase_q))));

    // R8: wrap under hold lands on seed A.
    a_r8_hold_returns_a: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wrap && hold_primary) |=> (phase_q == SEED_A));

    // R4: disabled cycles leave count and phase alone.
    a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(cnt_q) && $stable(phase_q)));

    // R5: phase only changes when the count restarts.
    a_r5_change_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != $past(phase_q)) |-> (cnt_q == '0));

endmodule

// File: rtl/jtp_scrambler.sv
module jtp_scrambler #(
    parameter int STATE_W = 58,
    parameter int DATA_W  = 64,
    parameter int TAP_LO  = 39,
    parameter int TAP_HI  = 58
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               load_seed,
    input  logic [STATE_W-1:0] seed,
    input  logic [DATA_W-1:0]  data,
    output logic [DATA_W-1:0]  scrambled
);

    localparam int IDX_LO = TAP_LO - 1;
    localparam int IDX_HI = TAP_HI - 1;

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] start_state;
    logic [STATE_W-1:0] end_state;

    assign start_state = load_seed ? seed : state_q;

    // LSB-first serial scrambler, unrolled over the block.
    always_comb begin
        logic [STATE_W-1:0] s;
        logic               b;
        s         = start_state;
        scrambled = '0;
        for (int i = 0; i < DATA_W; i++) begin
            b            = data[i] ^ s[IDX_LO] ^ s[IDX_HI];
            scrambled[i] = b;
            s            = {s[STATE_W-2:0], b};
        end
        end_state = s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (enable) begin
            state_q <= end_state;
        end
    end

    // R3: the newest output bit sits in state bit 0 after a block.
    a_r3_state_tracks_output: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> (state_q[0] == $past(scrambled[DATA_W-1])));

    // R4: no block, no state movement.
    a_r4_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(state_q));

endmodule

// File: rtl/jtp_gen.sv
module jtp_gen
    import jtp_pkg::*;
#(
    parameter int STATE_W  = 58,
    parameter int DATA_W   = 64,
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [STATE_W-1:0]  seed_a,
    input  logic [STATE_W-1:0]  seed_b,
    input  logic [DATA_W-1:0]   payload,
    input  logic [PERIOD_W-1:0] period,
    input  logic                hold_primary,
    output logic [1:0]          hdr_o,
    output logic [DATA_W-1:0]   blk_o,
    output logic                valid_o,
    output logic [1:0]          phase_o
);

    localparam logic [1:0] HDR_DATA = 2'b01;
    localparam logic [1:0] HDR_IDLE = 2'b00;

    jtp_phase_e          phase;
    logic                load_seed;
    logic                invert;
    logic [STATE_W-1:0]  seed_sel;
    logic [STATE_W-1:0]  seed_eff;
    logic [DATA_W-1:0]   data_eff;
    logic [DATA_W-1:0]   scrambled;

    jtp_phase_fsm #(.PERIOD_W(PERIOD_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .period       (period),
        .hold_primary (hold_primary),
        .phase        (phase),
        .load_seed    (load_seed),
        .invert       (invert)
    );

    always_comb begin
        seed_sel = phase_uses_b(phase) ? seed_b : seed_a;
        seed_eff = invert ? ~seed_sel : seed_sel;
        data_eff = invert ? ~payload  : payload;
    end

    jtp_scrambler #(
        .STATE_W (STATE_W),
        .DATA_W  (DATA_W),
        .TAP_LO  (39),
        .TAP_HI  (58)
    ) u_scr (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .load_seed (load_seed),
        .seed      (seed_eff),
        .data      (data_eff),
        .scrambled (scrambled)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_o   <= HDR_IDLE;
            blk_o   <= '0;
            valid_o <= 1'b0;
            phase_o <= 2'd0;
        end else begin
            valid_o <= enable;
            hdr_o   <= enable ? HDR_DATA : HDR_IDLE;
            if (enable) begin
                blk_o   <= scrambled;
                phase_o <= phase;
            end
        end
    end

    // R2: header tied to validity.
    a_r2_hdr_valid: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (hdr_o == HDR_DATA));
    a_r2_hdr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (hdr_o == HDR_IDLE));

    // R4: one block per enabled cycle, one cycle later.
    a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> valid_o);
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !valid_o);

    // R9: presented phase is the one active when the block was built.
    a_r9_phase_report: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> (phase_o == $past(phase)));

endmodule

// File: tb/tb_jtp_gen.sv
module tb_jtp_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic [57:0] seed_a, seed_b;
    logic [63:0] payload;
    logic [15:0] period;
    logic        hold_primary;
    logic [1:0]  hdr_o;
    logic [63:0] blk_o;
    logic        valid_o;
    logic [1:0]  phase_o;

    int n_checks = 0;
    int n_fails  = 0;

    // Reference model state
    logic [57:0] m_s;
    int          m_cnt;
    int          m_ph;

    always #2.5 clk = ~clk;

    jtp_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .seed_a(seed_a), .seed_b(seed_b), .payload(payload),
        .period(period), .hold_primary(hold_primary),
        .hdr_o(hdr_o), .blk_o(blk_o), .valid_o(valid_o), .phase_o(phase_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bit history model: out[i] = d[i] ^ out[i-39] ^ out[i-58].
    task automatic model_block(input logic [63:0] d, output logic [63:0] o);
        logic [121:0] h;
        logic [57:0]  seed;
        logic [63:0]  dd;
        int           eff;
        eff  = (period == 16'd0) ? 1 : int'(period);
        seed = (m_ph >= 2) ? seed_b : seed_a;
        dd   = d;
        if (m_ph == 1 || m_ph == 3) begin
            seed = ~seed;
            dd   = ~d;
        end
        if (m_cnt == 0) m_s = seed;
        h = '0;
        for (int j = 0; j < 58; j++) h[57-j] = m_s[j];
        for (int i = 0; i < 64; i++) begin
            h[58+i] = dd[i] ^ h[i+19] ^ h[i];
            o[i]    = h[58+i];
        end
        for (int j = 0; j < 58; j++) m_s[j] = h[121-j];
        if (m_cnt >= eff - 1) begin
            m_cnt = 0;
            m_ph  = hold_primary ? 0 : (m_ph + 1) % 4;
        end else begin
            m_cnt++;
        end
    endtask

    // One cycle: drive at negedge, check at following negedge.
    task automatic step(input logic en, input string req);
        logic [63:0] exp_blk;
        int          exp_ph;
        exp_ph  = m_ph;
        exp_blk = '0;
        enable  = en;
        if (en) model_block(payload, exp_blk);
        @(negedge clk);
        check({req, "/R4 valid"}, 64'(valid_o), 64'(en));
        if (en) begin
            check({req, "/R2 hdr"}, 64'(hdr_o), 64'h1);
            check({req, "/R3 blk"}, blk_o, exp_blk);
            check({req, "/R9 phase"}, 64'(phase_o), 64'(exp_ph));
        end else begin
            check({req, "/R2 idle hdr"}, 64'(hdr_o), 64'h0);
        end
    endtask

    task automatic do_reset();
        rst_n        = 1'b0;
        enable       = 1'b0;
        hold_primary = 1'b0;
        m_s   = '0;
        m_cnt = 0;
        m_ph  = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 valid", 64'(valid_o), 64'h0);
        check("R1 hdr", 64'(hdr_o), 64'h0);
        check("R1 phase", 64'(phase_o), 64'h0);
        seed_a = 58'h2A5_1234_5678_9ABC; seed_b = 58'h0F0_F0F0_1111_2222;
        payload = 64'hDEAD_BEEF_0123_4567; period = 16'd4;
        step(1'b1, "R1 first block seed A");
    endtask

    task automatic t_loop();
        do_reset();
        seed_a = 58'h155_5555_AAAA_0001; seed_b = 58'h3C3_C3C3_0000_FFFF;
        period = 16'd3;
        for (int k = 0; k < 16; k++) begin
            payload = (k < 8) ? 64'h0123_4567_89AB_CDEF : 64'hFFFF_0000_5A5A_A5A5;
            step(1'b1, "R5/R6 loop");
        end
    endtask

    task automatic t_pause();
        do_reset();
        seed_a = 58'h001_2345_6789_ABCD; seed_b = 58'h3FF_EDCB_A987_6543;
        payload = 64'hCAFE_F00D_1357_9BDF; period = 16'd2;
        step(1'b1, "R4 pause"); step(1'b0, "R4 pause"); step(1'b0, "R4 pause");
        step(1'b1, "R4 pause"); step(1'b1, "R4 pause"); step(1'b0, "R4 pause");
        step(1'b1, "R4 pause"); step(1'b1, "R4 pause"); step(1'b1, "R4 pause");
    endtask

    task automatic t_period_zero();
        do_reset();
        seed_a = 58'h2AA_0000_1234_0000; seed_b = 58'h111_2222_3333_4444;
        payload = 64'h8000_0000_0000_0001; period = 16'd0;
        for (int k = 0; k < 6; k++) step(1'b1, "R5 period zero");
        check("R6 phase after 6 single periods", 64'(phase_o), 64'd1);
    endtask

    task automatic t_hold();
        do_reset();
        seed_a = 58'h0AB_CDEF_0123_4567; seed_b = 58'h345_6789_ABCD_EF01;
        payload = 64'h0F0F_0F0F_F0F0_F0F0; period = 16'd2;
        step(1'b1, "R8"); step(1'b1, "R8"); step(1'b1, "R8");
        hold_primary = 1'b1;
        for (int k = 0; k < 7; k++) step(1'b1, "R8 hold");
        check("R8 phase held at A", 64'(phase_o), 64'd0);
        hold_primary = 1'b0;
        for (int k = 0; k < 3; k++) step(1'b1, "R8 release");
        check("R8 resumes with inverted A", 64'(phase_o), 64'd1);
    endtask

    task automatic t_complement();
        do_reset();
        seed_a = '0; seed_b = 58'h123_4567_89AB_CDEF;
        payload = '0; period = 16'd1;
        step(1'b1, "R7");
        check("R7 zero block", blk_o, 64'h0);
        step(1'b1, "R7");
        check("R7 inverted block all ones", blk_o, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    initial begin
        #(5ns * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        seed_a = '0; seed_b = '0; payload = '0; period = 16'd1;
        @(negedge clk);
        t_reset();
        t_loop();
        t_pause();
        t_period_zero();
        t_hold();
        t_complement();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule